// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache Controller

This block sits between a pipelined processor and main memory and holds one 32-bit word per line in a direct-mapped array. A load or fetch that finds its word in the array gets it back in the same cycle. A read that misses holds the processor through `cpu_stall`. While stalled, the controller lets any posted stores drain to memory, reads the word from memory and writes it into the line. The held access then completes as a hit on the next cycle.

Every store updates the line it indexes, whether or not the tag matched, and overwrites tag, data and the valid flag. The store is also queued in a four-entry posted buffer that feeds the memory write port. The processor waits on a store only when that buffer is full. The line index is taken from address bits `INDEX_W+1:2` and the tag from the bits above it. The default `INDEX_W` of 8 keeps elaboration small, and an `INDEX_W` of 14 gives an index of bits 15:2 with a tag of bits 31:16.

Back-pressure rules are as follows. A processor access completes in a cycle where `cpu_valid` is high and `cpu_stall` is low, and the processor holds its request steady while stalled. The memory write port is valid/ready: an entry moves on a cycle where both are high, and it stays unchanged until then. The memory read port raises `mem_rd_req` with a fixed address until the cycle in which memory raises `mem_rd_ack` together with `mem_rd_data`.

Top module: `wtc_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `mem_rd_req` and `mem_wr_valid` are low, `cpu_stall` is low with no request, and the first read of any address misses.
- R2: A read whose line is valid and whose stored tag equals the address tag returns the stored word on `cpu_rdata` in the same cycle with `cpu_stall` low.
- R3: A read miss raises `cpu_stall`, fetches the word from memory and writes it into the line with the address tag and valid set. One cycle after the `mem_rd_ack` cycle, the held read hits and returns the fetched word.
- R4: A store accepted while idle writes tag, word and valid into its line on a hit or a miss, with no memory read and no stall. A store to a different tag at the same index evicts the older line, so the older address misses afterwards.
- R5: Every accepted store appears on the memory write port once, in acceptance order, with its full 32-bit address and data.
- R6: The write buffer holds 4 stores. A store stalls only while all 4 entries are pending, and it never overflows the buffer.
- R7: A read miss does not raise `mem_rd_req` while any store is still pending in the buffer, so memory never returns data older than a posted store.
- R8: Address bits 1:0 play no part in the hit or the index, and the memory read address has bits 1:0 at zero.
- R9: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` stay unchanged on the next cycle.
- R10: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | Processor access present |
| cpu_we | input | 1 | 1 = store, 0 = load or fetch |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Read word, valid when a read completes |
| cpu_stall | output | 1 | Processor must hold its access |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Word-aligned memory read address |
| mem_rd_ack | input | 1 | Read data present this cycle |
| mem_rd_data | input | 32 | Word returned by memory |
| mem_wr_valid | output | 1 | Posted store offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered store |
| mem_wr_addr | output | 32 | Store address |
| mem_wr_data | output | 32 | Store word |

## Verification
Two functions can fall in the same cycle. The buffer can release its oldest entry to memory in the cycle a store arrives, and a pending read miss can wait on a buffer that is draining. The bench fills the buffer with the write port held off and then presents a fifth store. It checks that the stall rises and that the head entry stays unchanged, then opens the port and checks that the fifth store enters behind the drained head in order. A second case presents a read miss while a store is still parked. It checks that no memory read is issued until that store has left, and that the read then returns the word from memory.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  // one posted store
  typedef struct packed {
    addr_t addr;
    word_t data;
  } wb_entry_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_MISS = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wtc_lines.sv
module wtc_lines
  import wtc_pkg::*;
#(
  parameter int INDEX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:2] look_waddr,
  output logic              look_hit,
  output word_t             look_data,
  input  logic              upd_en,
  input  logic [ADDR_W-1:2] upd_waddr,
  input  word_t             upd_data
);
  localparam int LINES   = 1 << INDEX_W;
  localparam int TAG_LSB = INDEX_W + 2;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  word_t            data_q [LINES];

  logic [INDEX_W-1:0] look_idx, upd_idx;
  logic [TAG_W-1:0]   look_tag, upd_tag;

  assign look_idx = look_waddr[INDEX_W+1:2];
  assign look_tag = look_waddr[ADDR_W-1:TAG_LSB];
  assign upd_idx  = upd_waddr[INDEX_W+1:2];
  assign upd_tag  = upd_waddr[ADDR_W-1:TAG_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (upd_en) valid_q[upd_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q[upd_idx]  <= upd_tag;
      data_q[upd_idx] <= upd_data;
    end
  end

  assign look_hit  = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
  assign look_data = data_q[look_idx];
endmodule

// File: rtl/wtc_post_buf.sv
module wtc_post_buf
  import wtc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t push_entry,
  output logic      full,
  output logic      empty,
  output logic      out_valid,
  input  logic      out_ready,
  output wb_entry_t out_entry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  wb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign pop       = out_valid && out_ready;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign out_valid = !empty;
  assign out_entry = slot_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= step(tail_q);
      if (pop)  head_q <= step(head_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[tail_q] <= push_entry;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));
endmodule

// File: rtl/wtc_miss_seq.sv
module wtc_miss_seq
  import wtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:2] start_waddr,
  input  logic              drained,
  input  logic              rd_ack,
  output logic              busy,
  output logic              rd_req,
  output addr_t             rd_addr,
  output logic              fill
);
  seq_state_e        state_q;
  logic [ADDR_W-1:2] waddr_q;

  assign busy    = (state_q == SEQ_MISS);
  assign rd_req  = busy && drained;
  assign fill    = rd_req && rd_ack;
  assign rd_addr = {waddr_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      waddr_q <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_MISS;
          waddr_q <= start_waddr;
        end
        SEQ_MISS: if (fill) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/wtc_cache_ctrl.sv
module wtc_cache_ctrl
  import wtc_pkg::*;
#(
  parameter int INDEX_W  = 8,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data
);
  logic      look_hit, busy, fill, wb_full, wb_empty;
  logic      rd_miss, st_take, upd_en;
  word_t     look_data;
  wb_entry_t in_entry, head_entry;
  logic [ADDR_W-1:2] upd_waddr;

  assign rd_miss  = cpu_valid && !cpu_we && !look_hit && !busy;
  assign st_take  = cpu_valid && cpu_we && !busy && !wb_full;
  assign upd_en   = st_take || fill;
  assign upd_waddr = fill ? mem_rd_addr[ADDR_W-1:2] : cpu_addr[ADDR_W-1:2];

  assign cpu_stall = busy || (cpu_valid && (cpu_we ? wb_full : !look_hit));
  assign cpu_rdata = look_data;

  assign in_entry.addr = cpu_addr;
  assign in_entry.data = cpu_wdata;
  assign mem_wr_addr   = head_entry.addr;
  assign mem_wr_data   = head_entry.data;

  wtc_lines #(.INDEX_W(INDEX_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_waddr (cpu_addr[ADDR_W-1:2]),
    .look_hit   (look_hit),
    .look_data  (look_data),
    .upd_en     (upd_en),
    .upd_waddr  (upd_waddr),
    .upd_data   (fill ? mem_rd_data : cpu_wdata)
  );

  wtc_post_buf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (st_take),
    .push_entry (in_entry),
    .full       (wb_full),
    .empty      (wb_empty),
    .out_valid  (mem_wr_valid),
    .out_ready  (mem_wr_ready),
    .out_entry  (head_entry)
  );

  wtc_miss_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (rd_miss),
    .start_waddr (cpu_addr[ADDR_W-1:2]),
    .drained     (wb_empty),
    .rd_ack      (mem_rd_ack),
    .busy        (busy),
    .rd_req      (mem_rd_req),
    .rd_addr     (mem_rd_addr),
    .fill        (fill)
  );

  assert_drain_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !mem_wr_valid);

  assert_rd_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));
endmodule

// File: tb/wtc_cache_ctrl_bench.sv
module wtc_cache_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b1;
  logic [31:0] mem_wr_addr, mem_wr_data;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] log_addr [0:31];
  logic [31:0] log_data [0:31];
  int log_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  wtc_cache_ctrl u_wtc_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return a + 32'h1000_0000;
  endfunction

  // memory read side: ack three cycles after the request is seen
  always @(negedge clk) begin
    if (!rst_n || !mem_rd_req) begin
      rd_cnt = 0;
      mem_rd_ack = 1'b0;
    end else if (!mem_rd_ack) begin
      rd_cnt++;
      if (rd_cnt >= 3) begin
        mem_rd_ack  = 1'b1;
        mem_rd_data = mem_word(mem_rd_addr);
        last_rd_addr = mem_rd_addr;
      end
    end
  end

  // memory write side
  always @(posedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      mem_model[mem_wr_addr] = mem_wr_data;
      if (log_cnt < 32) begin
        log_addr[log_cnt] = mem_wr_addr;
        log_data[log_cnt] = mem_wr_data;
      end
      log_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    stalls = 0;
    #1;
    while (cpu_stall && stalls < 200) begin
      stalls++;
      @(negedge clk); #1;
    end
    rd = cpu_rdata;
    @(posedge clk); #2;
    cpu_valid = 1'b0;
  endtask

  // {we, addr, wdata, expected read word, expect miss}
  localparam int NV = 10;
  localparam logic [97:0] VEC [0:NV-1] = '{
    {1'b0, 32'h0000_0040, 32'h0,          32'h1000_0040, 1'b1}, // first read misses
    {1'b0, 32'h0000_0040, 32'h0,          32'h1000_0040, 1'b0}, // hit
    {1'b0, 32'h0000_0043, 32'h0,          32'h1000_0040, 1'b0}, // low bits ignored
    {1'b1, 32'h0000_0040, 32'hDEAD_0001,  32'h0,         1'b0}, // store hit
    {1'b0, 32'h0000_0040, 32'h0,          32'hDEAD_0001, 1'b0}, // new word seen
    {1'b1, 32'h0001_0040, 32'hBEEF_0002,  32'h0,         1'b0}, // store miss, evicts
    {1'b0, 32'h0001_0040, 32'h0,          32'hBEEF_0002, 1'b0}, // hit, no fetch
    {1'b0, 32'h0000_0040, 32'h0,          32'hDEAD_0001, 1'b1}, // evicted, from memory
    {1'b0, 32'h0001_0040, 32'h0,          32'hBEEF_0002, 1'b1}, // evicted again
    {1'b0, 32'h0000_0080, 32'h0,          32'h1000_0080, 1'b1}  // other line
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); #1;
    chk("R1 stall idle", {31'b0, cpu_stall}, 32'd0);
    chk("R1 rd_req", {31'b0, mem_rd_req}, 32'd0);
    chk("R1 wr_valid", {31'b0, mem_wr_valid}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [97:0] v;
      v = VEC[i];
      access(v[97], v[96:65], v[64:33], rd, st);
      if (v[97]) begin
        chk("R4 store no stall", st, 0);
      end else begin
        chk("R2 read word", rd, v[32:1]);
        chk("R3 miss seen", {31'b0, (st > 0)}, {31'b0, v[0]});
      end
    end

    // R8: unaligned read miss goes out aligned
    access(1'b0, 32'h0000_6006, 32'h0, rd, st);
    chk("R8 rd addr aligned", last_rd_addr, 32'h0000_6004);
    chk("R8 word", rd, 32'h1000_6004);

    // R6/R9/R5: fill buffer with port held off
    repeat (4) @(posedge clk);
    log_cnt = 0;
    mem_wr_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      access(1'b1, 32'h0000_2000 + 32'(k * 4), 32'h5000_0000 + 32'(k), rd, st);
      chk("R6 store accepted", st, 0);
    end
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h0000_2010; cpu_wdata = 32'h5000_0004;
    #1;
    chk("R6 full stalls", {31'b0, cpu_stall}, 32'd1);
    chk("R9 head addr", mem_wr_addr, 32'h0000_2000);
    @(negedge clk); #1;
    chk("R9 head valid held", {31'b0, mem_wr_valid}, 32'd1);
    chk("R9 head addr held", mem_wr_addr, 32'h0000_2000);
    chk("R9 head data held", mem_wr_data, 32'h5000_0000);
    chk("R6 still stalled", {31'b0, cpu_stall}, 32'd1);
    mem_wr_ready = 1'b1;
    @(negedge clk); #1;
    chk("R6 slot freed", {31'b0, cpu_stall}, 32'd0);
    @(posedge clk); #2;
    cpu_valid = 1'b0;
    repeat (8) @(posedge clk);
    #2;
    chk("R5 store count", log_cnt, 5);
    for (int k = 0; k < 5; k++) begin
      chk("R5 order addr", log_addr[k], 32'h0000_2000 + 32'(k * 4));
      chk("R5 order data", log_data[k], 32'h5000_0000 + 32'(k));
    end

    // R7/R10: read miss waits behind a parked store
    mem_wr_ready = 1'b0;
    access(1'b1, 32'h0000_3000, 32'h7777_0001, rd, st);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h0000_3000 + 32'h0004_0000;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7 no read while pending", {31'b0, mem_rd_req}, 32'd0);
      chk("R3 stalled", {31'b0, cpu_stall}, 32'd1);
      @(negedge clk);
    end
    mem_wr_ready = 1'b1;
    @(negedge clk); #1;
    chk("R10 req up", {31'b0, mem_rd_req}, 32'd1);
    chk("R10 addr", mem_rd_addr, 32'h0004_3000);
    @(negedge clk); #1;
    chk("R10 req held", {31'b0, mem_rd_req}, 32'd1);
    chk("R10 addr held", mem_rd_addr, 32'h0004_3000);
    st = 0;
    while (cpu_stall && st < 50) begin
      st++;
      @(negedge clk); #1;
    end
    chk("R3 filled word", cpu_rdata, 32'h1004_3000);
    @(posedge clk); #2;
    cpu_valid = 1'b0;
    access(1'b0, 32'h0000_3000, 32'h0, rd, st);
    chk("R7 store reached memory", rd, 32'h7777_0001);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule